// File: doc/BRIEF.md
# Uncached Write-Combining Store Gatherer

This block sits on a core's store path in front of the memory interface. Every store arrives with a 3-bit memory attribute. Plain uncached stores (code 2) go straight to memory as single blocking transfers. Accelerated uncached stores (code 7) are not sent one by one. When they follow each other through consecutive byte addresses, the block collects them into a 32-byte line buffer. A completely filled line leaves as one burst write.

Some stores break a running sequence: a plain uncached store, or an accelerated store that does not continue the sequence. When one of these arrives, the block first empties the partly filled buffer. It does this through a single-byte write port, lowest address first, and sends only the bytes that were written. After that it handles the breaking store. The input handshake stays low while a burst, a byte drain or a pass-through transfer is outstanding. Every other attribute code (cacheable coherent and the reserved values) is accepted and discarded.

The controller is a four-state machine:
- GATHER is the idle and collecting state. Its exits are: PASS on an accepted code-2 store, BURST on the accelerated store that fills the last empty byte, and DRAIN when a breaking store waits while the buffer holds data.
- BURST returns to GATHER when the burst is taken.
- DRAIN returns to GATHER when the last valid byte is taken.
- PASS returns to GATHER when the single transfer is taken.

Top module: `wc_store_gather`

## Requirements
- R1: After reset `st_ready` is high and `bw_valid`, `sw_valid` and `ux_valid` are low.
- R2: A store with attribute 2 that meets an empty buffer is accepted and then appears once on the pass-through port, with `ux_addr`, `ux_data` and `ux_be` equal to the store's address, data and byte enables.
- R3: Each accelerated (attribute 7) store writes its enabled lanes into line byte `{st_addr[4:3], lane}`. The store continues the sequence when it targets the same line (`st_addr[39:5]`) and its lowest enabled byte sits directly after the highest enabled byte of the previously gathered store.
- R4: When all 32 line bytes have been filled, exactly one burst is issued. `bw_addr` is the line address with bits 4:0 zero, and byte k of `bw_data` (bits 8k+7:8k) is line byte k.
- R5: An attribute-2 store that arrives while the buffer holds data is held off until the buffer has been drained as byte writes. Only then is it passed through.
- R6: An accelerated store that does not continue the sequence, including one to another line, first drains the buffer. It then starts a new gather with its own bytes.
- R7: A drain emits only the bytes that were written, one per `sw_valid`/`sw_ready` handshake, in strictly ascending address order. `sw_addr` is the full byte address.
- R8: Stores with attribute codes other than 2 and 7 are accepted and dropped. They produce no output and leave the buffer contents and the sequence unchanged.
- R9: `st_ready` is low whenever any output valid is high, and at most one output valid is high at a time.
- R10: An output whose valid is high and whose ready is low keeps its valid, address and data stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted on this edge when valid |
| st_addr | input | ADDR_W | Store address; bits 4:3 select the doubleword |
| st_data | input | DATA_W | Store data, byte lanes |
| st_be | input | DATA_W/8 | Contiguous byte-lane enables |
| st_attr | input | 3 | Memory attribute code |
| bw_valid | output | 1 | Full-line burst present |
| bw_ready | input | 1 | Burst taken |
| bw_addr | output | ADDR_W | Line-aligned burst address |
| bw_data | output | 8*LINE_BYTES | Line contents, byte k at bits 8k+7:8k |
| sw_valid | output | 1 | Drain byte present |
| sw_ready | input | 1 | Drain byte taken |
| sw_addr | output | ADDR_W | Byte address |
| sw_data | output | 8 | Byte value |
| ux_valid | output | 1 | Pass-through store present |
| ux_ready | input | 1 | Pass-through store taken |
| ux_addr | output | ADDR_W | Pass-through address |
| ux_data | output | DATA_W | Pass-through data |
| ux_be | output | DATA_W/8 | Pass-through byte enables |

## Verification
The bench targets the following corner cases. Each one would expose a specific mistake.
- **Sequence starting mid-line and running off the end.** A gather starts part-way into a line and reaches byte 31. The next store goes to the following line. A design that wrapped its next-offset counter would treat that store as a continuation instead of draining 16 bytes.
- **Gap inside a doubleword.** A store leaves a one-byte hole. A design that compared doubleword addresses instead of byte positions would keep gathering instead of draining.
- **Drain content and order.** Drains carry holes in the mask. A design that emitted unwritten bytes, or emitted them out of order, would produce byte writes the model does not expect.
- **Interleaved foreign attributes.** Codes 0 and 3 are mixed into a running gather. A design that let them reset or write the buffer would lose or corrupt the gathered bytes.
- **Output stalls.** Every scenario is repeated with random output stalls. A design that changed its outputs before the handshake, or that accepted stores during a drain, would fail the comparison.

// File: rtl/wcg_pkg.sv
package wcg_pkg;
    typedef enum logic [1:0] {
        ST_GATHER,
        ST_BURST,
        ST_DRAIN,
        ST_PASS
    } wcg_state_e;

    localparam logic [2:0] ATTR_UNCACHED = 3'd2;
    localparam logic [2:0] ATTR_ACCEL    = 3'd7;
endpackage

// File: rtl/wcg_store_decode.sv
// Finds the first byte offset and the offset just past the last byte of a store.
module wcg_store_decode #(
    parameter int LANES  = 8,
    parameter int LANE_W = 3,
    parameter int OFF_W  = 5
) (
    input  logic [LANES-1:0]        be,
    input  logic [OFF_W-LANE_W-1:0] dw_sel,
    output logic [OFF_W-1:0]        first_off,
    output logic [OFF_W:0]          end_off
);
    logic [LANE_W-1:0] lo_lane;
    logic [LANE_W-1:0] hi_lane;
    logic              seen;

    always_comb begin
        lo_lane = '0;
        hi_lane = '0;
        seen    = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (be[i] && !seen) begin
                lo_lane = LANE_W'(i);
                seen    = 1'b1;
            end
            if (be[i]) begin
                hi_lane = LANE_W'(i);
            end
        end
    end

    assign first_off = {dw_sel, lo_lane};
    assign end_off   = {1'b0, dw_sel, hi_lane} + (OFF_W+1)'(1);
endmodule

// File: rtl/wcg_pick_lowest.sv
// Priority encoder: index of the lowest set bit.
module wcg_pick_lowest #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/wcg_line_buf.sv
// Line-sized byte store with a per-byte filled mask.
module wcg_line_buf #(
    parameter int LINE_BYTES = 32,
    parameter int LANES      = 8,
    parameter int OFF_W      = 5,
    parameter int LANE_W     = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [OFF_W-LANE_W-1:0]   wr_dw,
    input  logic [LANES-1:0]          wr_be,
    input  logic [8*LANES-1:0]        wr_data,
    input  logic                      clr_all,
    input  logic                      clr_byte,
    input  logic [OFF_W-1:0]          clr_idx,
    output logic [8*LINE_BYTES-1:0]   line_data,
    output logic [LINE_BYTES-1:0]     mask,
    output logic                      full_if_wr
);
    localparam int DWS_W = OFF_W - LANE_W;

    logic [LINE_BYTES-1:0] set_nx;

    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_byte
        localparam int DW_IDX = g / LANES;
        localparam int LN     = g % LANES;

        logic       m_q;
        logic [7:0] d_q;
        logic       hit;

        assign hit = (wr_dw == DWS_W'(DW_IDX)) && wr_be[LN];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                m_q <= 1'b0;
            end else if (clr_all || (clr_byte && clr_idx == OFF_W'(g))) begin
                m_q <= 1'b0;
            end else if (wr_en && hit) begin
                m_q <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && hit) begin
                d_q <= wr_data[8*LN +: 8];
            end
        end

        assign mask[g]            = m_q;
        assign line_data[8*g +: 8] = d_q;
        assign set_nx[g]          = m_q | hit;
    end

    assign full_if_wr = &set_nx;
endmodule

// File: rtl/wc_store_gather.sv
module wc_store_gather
    import wcg_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    input  logic [DATA_W/8-1:0]     st_be,
    input  logic [2:0]              st_attr,
    output logic                    bw_valid,
    input  logic                    bw_ready,
    output logic [ADDR_W-1:0]       bw_addr,
    output logic [8*LINE_BYTES-1:0] bw_data,
    output logic                    sw_valid,
    input  logic                    sw_ready,
    output logic [ADDR_W-1:0]       sw_addr,
    output logic [7:0]              sw_data,
    output logic                    ux_valid,
    input  logic                    ux_ready,
    output logic [ADDR_W-1:0]       ux_addr,
    output logic [DATA_W-1:0]       ux_data,
    output logic [DATA_W/8-1:0]     ux_be
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LINE_W = ADDR_W - OFF_W;

    wcg_state_e st_q, st_nx;

    logic [LINE_W-1:0]       line_q;
    logic [OFF_W:0]          next_q;
    logic [ADDR_W-1:0]       ux_addr_q;
    logic [DATA_W-1:0]       ux_data_q;
    logic [LANES-1:0]        ux_be_q;

    logic [LINE_W-1:0]       st_line;
    logic [OFF_W-1:0]        first_off;
    logic [OFF_W:0]          end_off;
    logic [8*LINE_BYTES-1:0] line_data;
    logic [LINE_BYTES-1:0]   mask;
    logic [OFF_W-1:0]        pick_idx;
    logic                    full_if_wr;

    logic is_unc, is_accel, buf_empty, continues, brk, accept, last_byte;
    logic buf_wr, clr_all, clr_byte, cap_pass, cap_seq;

    assign st_line   = st_addr[ADDR_W-1:OFF_W];
    assign is_unc    = (st_attr == ATTR_UNCACHED);
    assign is_accel  = (st_attr == ATTR_ACCEL);
    assign buf_empty = ~|mask;
    assign continues = (st_line == line_q) && ({1'b0, first_off} == next_q);
    assign brk       = !buf_empty && (is_unc || (is_accel && !continues));
    assign accept    = st_valid && st_ready;
    assign last_byte = ($countones(mask) == 1);

    wcg_store_decode #(
        .LANES (LANES),
        .LANE_W(LANE_W),
        .OFF_W (OFF_W)
    ) dec_i (
        .be       (st_be),
        .dw_sel   (st_addr[OFF_W-1:LANE_W]),
        .first_off(first_off),
        .end_off  (end_off)
    );

    wcg_line_buf #(
        .LINE_BYTES(LINE_BYTES),
        .LANES     (LANES),
        .OFF_W     (OFF_W),
        .LANE_W    (LANE_W)
    ) buf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (buf_wr),
        .wr_dw     (st_addr[OFF_W-1:LANE_W]),
        .wr_be     (st_be),
        .wr_data   (st_data),
        .clr_all   (clr_all),
        .clr_byte  (clr_byte),
        .clr_idx   (pick_idx),
        .line_data (line_data),
        .mask      (mask),
        .full_if_wr(full_if_wr)
    );

    wcg_pick_lowest #(
        .N (LINE_BYTES),
        .IW(OFF_W)
    ) pick_i (
        .vec(mask),
        .idx(pick_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_GATHER;
        end else begin
            st_q <= st_nx;
        end
    end

    // Transitions and buffer control
    always_comb begin
        st_nx    = st_q;
        buf_wr   = 1'b0;
        clr_all  = 1'b0;
        clr_byte = 1'b0;
        cap_pass = 1'b0;
        cap_seq  = 1'b0;
        unique case (st_q)
            ST_GATHER: begin
                if (accept && is_unc) begin
                    cap_pass = 1'b1;
                    st_nx    = ST_PASS;
                end else if (accept && is_accel) begin
                    buf_wr  = 1'b1;
                    cap_seq = 1'b1;
                    if (full_if_wr) begin
                        st_nx = ST_BURST;
                    end
                end else if (st_valid && brk) begin
                    st_nx = ST_DRAIN;
                end
            end
            ST_BURST: begin
                if (bw_ready) begin
                    clr_all = 1'b1;
                    st_nx   = ST_GATHER;
                end
            end
            ST_DRAIN: begin
                if (sw_ready) begin
                    clr_byte = 1'b1;
                    if (last_byte) begin
                        st_nx = ST_GATHER;
                    end
                end
            end
            ST_PASS: begin
                if (ux_ready) begin
                    st_nx = ST_GATHER;
                end
            end
            default: st_nx = ST_GATHER;
        endcase
    end

    // Sequence tracking and pass-through capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            next_q <= '0;
        end else if (cap_seq) begin
            line_q <= st_line;
            next_q <= end_off;
        end
    end

    always_ff @(posedge clk) begin
        if (cap_pass) begin
            ux_addr_q <= st_addr;
            ux_data_q <= st_data;
            ux_be_q   <= st_be;
        end
    end

    // Outputs
    always_comb begin
        st_ready = (st_q == ST_GATHER) && !brk;
        bw_valid = (st_q == ST_BURST);
        sw_valid = (st_q == ST_DRAIN);
        ux_valid = (st_q == ST_PASS);
        bw_addr  = {line_q, {OFF_W{1'b0}}};
        bw_data  = line_data;
        sw_addr  = {line_q, pick_idx};
        sw_data  = line_data[{pick_idx, 3'b000} +: 8];
        ux_addr  = ux_addr_q;
        ux_data  = ux_data_q;
        ux_be    = ux_be_q;
    end
endmodule

// File: rtl/wcg_checker.sv
module wcg_checker #(
    parameter int ADDR_W     = 40,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_ready,
    input logic                    bw_valid,
    input logic                    bw_ready,
    input logic [ADDR_W-1:0]       bw_addr,
    input logic [8*LINE_BYTES-1:0] bw_data,
    input logic                    sw_valid,
    input logic                    sw_ready,
    input logic [ADDR_W-1:0]       sw_addr,
    input logic [7:0]              sw_data,
    input logic                    ux_valid,
    input logic                    ux_ready,
    input logic [ADDR_W-1:0]       ux_addr,
    input logic [DATA_W-1:0]       ux_data,
    input logic [DATA_W/8-1:0]     ux_be
);
    assert_one_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bw_valid, sw_valid, ux_valid}));

    assert_input_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid || sw_valid || ux_valid) |-> !st_ready);

    assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr) && $stable(bw_data)));

    assert_byte_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && !sw_ready) |=> (sw_valid && $stable(sw_addr) && $stable(sw_data)));

    assert_pass_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ux_valid && !ux_ready) |=>
            (ux_valid && $stable(ux_addr) && $stable(ux_data) && $stable(ux_be)));

    assert_drain_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_valid && sw_ready) |=> (!sw_valid || (sw_addr > $past(sw_addr))));

    assert_single_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_valid && bw_ready) |=> !bw_valid);
endmodule

bind wc_store_gather wcg_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LINE_BYTES(LINE_BYTES)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .st_ready(st_ready),
    .bw_valid(bw_valid),
    .bw_ready(bw_ready),
    .bw_addr (bw_addr),
    .bw_data (bw_data),
    .sw_valid(sw_valid),
    .sw_ready(sw_ready),
    .sw_addr (sw_addr),
    .sw_data (sw_data),
    .ux_valid(ux_valid),
    .ux_ready(ux_ready),
    .ux_addr (ux_addr),
    .ux_data (ux_data),
    .ux_be   (ux_be)
);

// File: tb/wc_store_gather_tb_top.sv
module wc_store_gather_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [39:0]  st_addr = '0;
    logic [63:0]  st_data = '0;
    logic [7:0]   st_be = '0;
    logic [2:0]   st_attr = '0;
    logic         bw_valid, bw_ready = 1'b1;
    logic [39:0]  bw_addr;
    logic [255:0] bw_data;
    logic         sw_valid, sw_ready = 1'b1;
    logic [39:0]  sw_addr;
    logic [7:0]   sw_data;
    logic         ux_valid, ux_ready = 1'b1;
    logic [39:0]  ux_addr;
    logic [63:0]  ux_data;
    logic [7:0]   ux_be;

    int  checks = 0;
    int  fails  = 0;
    int  stall_mode = 0;
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wc_store_gather dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_attr(st_attr),
        .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr), .bw_data(bw_data),
        .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_addr(sw_addr), .sw_data(sw_data),
        .ux_valid(ux_valid), .ux_ready(ux_ready), .ux_addr(ux_addr),
        .ux_data(ux_data), .ux_be(ux_be)
    );

    // Reference model state
    logic [7:0]   mbuf [32];
    logic [31:0]  mmask = '0;
    logic [34:0]  mline = '0;
    int           mnext = 0;

    logic [39:0]  eb_addr [$];
    logic [255:0] eb_data [$];
    logic [39:0]  es_addr [$];
    logic [7:0]   es_data [$];
    logic [39:0]  eu_addr [$];
    logic [63:0]  eu_data [$];
    logic [7:0]   eu_be   [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic void model_flush();
        for (int k = 0; k < 32; k++) begin
            if (mmask[k]) begin
                es_addr.push_back({mline, 5'(k)});
                es_data.push_back(mbuf[k]);
            end
        end
        mmask = '0;
    endfunction

    function automatic void model_store(logic [39:0] a, logic [63:0] d,
                                        logic [7:0] be, logic [2:0] attr);
        int lo = -1, hi = 0, base;
        logic [255:0] line;
        for (int i = 0; i < 8; i++) begin
            if (be[i]) begin
                if (lo < 0) lo = i;
                hi = i;
            end
        end
        base = int'(a[4:3]) * 8;
        if (attr == 3'd7) begin
            // R3 / R6: continuation test on byte positions
            if (mmask != 0 && !(a[39:5] == mline && base + lo == mnext)) model_flush();
            for (int i = 0; i < 8; i++) begin
                if (be[i]) begin
                    mbuf[base+i] = d[8*i +: 8];
                    mmask[base+i] = 1'b1;
                end
            end
            mline = a[39:5];
            mnext = base + hi + 1;
            if (&mmask) begin
                for (int k = 0; k < 32; k++) line[8*k +: 8] = mbuf[k];
                eb_addr.push_back({mline, 5'd0});
                eb_data.push_back(line);
                mmask = '0;
            end
        end else if (attr == 3'd2) begin
            if (mmask != 0) model_flush();   // R5
            eu_addr.push_back(a);
            eu_data.push_back(d);
            eu_be.push_back(be);
        end
        // R8: other codes change nothing
    endfunction

    task automatic send(input logic [39:0] a, input logic [63:0] d,
                        input logic [7:0] be, input logic [2:0] attr);
        bit acc = 0;
        model_store(a, d, be, attr);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_attr = attr;
        while (!acc) begin
            #1;
            acc = st_ready;
            @(negedge clk);
        end
        st_valid = 1'b0;
    endtask

    // Output readiness pattern
    always @(negedge clk) begin
        if (stall_mode == 0) begin
            bw_ready = 1'b1; sw_ready = 1'b1; ux_ready = 1'b1;
        end else begin
            bw_ready = ($urandom % 3) == 0;
            sw_ready = ($urandom % 2) == 0;
            ux_ready = ($urandom % 3) == 0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            if (bw_valid || sw_valid || ux_valid)
                check(!st_ready, "R9", "st_ready during output", 256'(st_ready), 256'(0));
            if (bw_valid && bw_ready) begin
                if (eb_addr.size() == 0) check(0, "R4", "unexpected burst", 256'(bw_addr), 256'(0));
                else begin
                    check(bw_addr == eb_addr[0], "R4", "burst addr", 256'(bw_addr), 256'(eb_addr[0]));
                    check(bw_data == eb_data[0], "R4", "burst data", bw_data, eb_data[0]);
                    void'(eb_addr.pop_front()); void'(eb_data.pop_front());
                end
            end
            if (sw_valid && sw_ready) begin
                if (es_addr.size() == 0) check(0, "R7", "unexpected byte write", 256'(sw_addr), 256'(0));
                else begin
                    check(sw_addr == es_addr[0], "R7", "byte addr", 256'(sw_addr), 256'(es_addr[0]));
                    check(sw_data == es_data[0], "R7", "byte data", 256'(sw_data), 256'(es_data[0]));
                    void'(es_addr.pop_front()); void'(es_data.pop_front());
                end
            end
            if (ux_valid && ux_ready) begin
                if (eu_addr.size() == 0) check(0, "R2", "unexpected pass", 256'(ux_addr), 256'(0));
                else begin
                    check(ux_addr == eu_addr[0], "R2", "pass addr", 256'(ux_addr), 256'(eu_addr[0]));
                    check(ux_data == eu_data[0], "R2", "pass data", 256'(ux_data), 256'(eu_data[0]));
                    check(ux_be == eu_be[0], "R2", "pass be", 256'(ux_be), 256'(eu_be[0]));
                    void'(eu_addr.pop_front()); void'(eu_data.pop_front()); void'(eu_be.pop_front());
                end
            end
        end
    end

    task automatic scenarios();
        logic [39:0] la = 40'h12_3456_7800;
        logic [39:0] lb = 40'h00_0000_1000;
        logic [39:0] lc = 40'h0A_0000_0040;
        // R3 R4: four full doublewords fill one line
        for (int i = 0; i < 4; i++) send(la + 40'(8*i), {$urandom, $urandom}, 8'hFF, 3'd7);
        // R2: pass-through with empty buffer
        send(40'h00_0000_0104, {$urandom, $urandom}, 8'h0F, 3'd2);
        // R5 R7: partial gather then plain uncached store
        send(la, {$urandom, $urandom}, 8'h0F, 3'd7);
        send(la, {$urandom, $urandom}, 8'hF0, 3'd7);
        send(lb, {$urandom, $urandom}, 8'hFF, 3'd2);
        // R6: mid-line start, broken by unrelated line, new gather fills lb
        send(la + 40'd8, {$urandom, $urandom}, 8'hFF, 3'd7);
        for (int i = 0; i < 4; i++) send(lb + 40'(8*i), {$urandom, $urandom}, 8'hFF, 3'd7);
        // R6: sequence runs to byte 31 then continues on next line
        send(lc + 40'd16, {$urandom, $urandom}, 8'hFF, 3'd7);
        send(lc + 40'd24, {$urandom, $urandom}, 8'hFF, 3'd7);
        send(lc + 40'd32, {$urandom, $urandom}, 8'hFF, 3'd7);
        // R8: foreign attributes interleaved with a gather
        send(lc + 40'd40, {$urandom, $urandom}, 8'h03, 3'd7);
        send(lc + 40'd40, {$urandom, $urandom}, 8'hFF, 3'd3);
        send(la, {$urandom, $urandom}, 8'hFF, 3'd0);
        send(lc + 40'd40, {$urandom, $urandom}, 8'h0C, 3'd7);
        send(lc, {$urandom, $urandom}, 8'h01, 3'd2);
        // R6 R7: one-byte gap inside a doubleword
        send(lb, {$urandom, $urandom}, 8'h01, 3'd7);
        send(lb, {$urandom, $urandom}, 8'h04, 3'd7);
        send(lb + 40'd8, {$urandom, $urandom}, 8'h30, 3'd2);
        // R3 R4: byte-sized stores fill a line
        for (int k = 0; k < 32; k++)
            send(la + 40'(k & 24), {$urandom, $urandom}, 8'(1 << (k % 8)), 3'd7);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        check(st_ready == 1'b1, "R1", "st_ready after reset", 256'(st_ready), 256'(1));
        check({bw_valid, sw_valid, ux_valid} == 3'b000, "R1", "valids after reset",
              256'({bw_valid, sw_valid, ux_valid}), 256'(0));
        stall_mode = 0;
        scenarios();
        stall_mode = 1;
        scenarios();
        repeat (60) @(negedge clk);
        #2;
        check(eb_addr.size() == 0, "R4", "bursts outstanding", 256'(eb_addr.size()), 256'(0));
        check(es_addr.size() == 0, "R7", "bytes outstanding", 256'(es_addr.size()), 256'(0));
        check(eu_addr.size() == 0, "R2", "passes outstanding", 256'(eu_addr.size()), 256'(0));
        check(st_ready == 1'b1, "R9", "idle ready", 256'(st_ready), 256'(1));
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule